// File: doc/BRIEF.md
# T-Flag Subtract, Negate and Extension Unit

This block is one execution slice of a 32-bit RISC core. Each clock cycle it takes a 16-bit instruction word and the current contents of the two source registers (the destination-and-source operand "Rn" and the second operand "Rm"). It produces the value to be written back to Rn together with a write strobe. A single status bit, the T flag, lives inside the block. Depending on the instruction, T is used as a borrow, as a signed-underflow indicator or as a zero-test result.

All supported operations share one subtractor. This covers plain, borrow-chained and underflow-checked subtraction, plain and borrow-chained negation, and decrement-with-zero-test. A separate extender sign- or zero-extends the low byte or low halfword of Rm. The result, the write strobe, the T register and a T-update strobe are registered together on the clock edge that follows the cycle in which the instruction is presented. An instruction issued in the very next cycle therefore already sees the updated T.

Top module: `tflag_exec_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `res_o` becomes 0 and `res_we_o`, `t_we_o` and `t_o` become 0.
- R2: Each operation takes one cycle. Its outputs appear on the edge after presentation, a new instruction can be accepted every cycle, and an instruction reads the T produced by the instruction of the previous cycle.
- R3: Opcode `0011nnnnmmmm1000` writes Rn − Rm (modulo 2^32). It asserts `res_we_o` and leaves T unchanged, with `t_we_o` low.
- R4: Opcode `0011nnnnmmmm1010` writes Rn − Rm − T. T becomes the unsigned borrow out, and `t_we_o` is asserted.
- R5: Opcode `0011nnnnmmmm1011` writes Rn − Rm. T becomes 1 exactly when Rn and Rm have opposite sign bits and the result's sign bit differs from Rn's.
- R6: Opcode `0110nnnnmmmm1011` writes 0 − Rm and leaves T unchanged.
- R7: Opcode `0110nnnnmmmm1010` writes 0 − Rm − T. T becomes the borrow, which is 1 whenever Rm is nonzero or T was 1.
- R8: Opcode `0100nnnn00010000` writes Rn − 1. T becomes 1 if that result is zero and 0 otherwise.
- R9: Opcodes `0110nnnnmmmm1110` and `0110nnnnmmmm1111` write the sign extension of Rm bits 7:0 and of bits 15:0 respectively, and leave T unchanged.
- R10: Opcodes `0110nnnnmmmm1100` and `0110nnnnmmmm1101` write the zero extension of Rm bits 7:0 and of bits 15:0 respectively, and leave T unchanged.
- R11: Any other opcode, including `0100nnnn00010001` and `0xFFFF`, leaves both `res_we_o` and `t_we_o` low and T unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 16 | Instruction word |
| rn_i | input | 32 | Current value of Rn |
| rm_i | input | 32 | Current value of Rm |
| res_o | output | 32 | Registered value to write to Rn |
| res_we_o | output | 1 | Registered write strobe for Rn |
| t_o | output | 1 | T flag register |
| t_we_o | output | 1 | High for the cycle after T was updated |

## Verification
Two things can happen in the same cycle. The borrow-chained subtract can write T, while the next instruction, already waiting at the inputs, consumes that T through its carry-in. The bench provokes this by running the low and high halves of a 64-bit subtraction on consecutive cycles, with no idle cycle between them. It then judges both the high-word result and the final borrow against a 64-bit difference that the bench computes itself. Negate-with-borrow directly after a flag-setting decrement exercises the same overlap along a second path.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  typedef enum logic [3:0] {
    K_NONE,
    K_SUB,
    K_SUBC,
    K_SUBV,
    K_NEG,
    K_NEGC,
    K_DT,
    K_EXTSB,
    K_EXTSW,
    K_EXTUB,
    K_EXTUW
  } op_kind_e;

  localparam int unsigned OP_W = 16;
endpackage

// File: rtl/tfu_decode.sv
module tfu_decode
  import tfu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_kind_e        kind
);
  logic [3:0] major;
  logic [3:0] minor;

  assign major = op[15:12];
  assign minor = op[3:0];

  always_comb begin
    kind = K_NONE;
    unique case (major)
      4'h3: begin
        case (minor)
          4'h8:    kind = K_SUB;
          4'hA:    kind = K_SUBC;
          4'hB:    kind = K_SUBV;
          default: kind = K_NONE;
        endcase
      end
      4'h4: begin
        if (op[7:0] == 8'h10) kind = K_DT;
      end
      4'h6: begin
        case (minor)
          4'hA:    kind = K_NEGC;
          4'hB:    kind = K_NEG;
          4'hC:    kind = K_EXTUB;
          4'hD:    kind = K_EXTUW;
          4'hE:    kind = K_EXTSB;
          4'hF:    kind = K_EXTSW;
          default: kind = K_NONE;
        endcase
      end
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/tfu_subtract.sv
module tfu_subtract #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  output logic [XLEN-1:0] diff,
  output logic            borrow,
  output logic            underflow
);
  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN:0] full;

  assign full      = {1'b0, a} - {1'b0, b} - {{XLEN{1'b0}}, cin};
  assign diff      = full[MSB:0];
  assign borrow    = full[XLEN];
  assign underflow = (a[MSB] != b[MSB]) && (full[MSB] != a[MSB]);
endmodule

// File: rtl/tfu_extend.sv
module tfu_extend #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic [XLEN-1:0] src,
  input  logic            wide,
  input  logic            signed_ext,
  output logic [XLEN-1:0] dst
);
  localparam int unsigned BYTE_PAD = XLEN - BYTE_W;
  localparam int unsigned HALF_PAD = XLEN - HALF_W;

  logic [XLEN-1:0] byte_val;
  logic [XLEN-1:0] half_val;
  logic            byte_fill;
  logic            half_fill;

  assign byte_fill = signed_ext & src[BYTE_W-1];
  assign half_fill = signed_ext & src[HALF_W-1];
  assign byte_val  = {{BYTE_PAD{byte_fill}}, src[BYTE_W-1:0]};
  assign half_val  = {{HALF_PAD{half_fill}}, src[HALF_W-1:0]};
  assign dst       = wide ? half_val : byte_val;
endmodule

// File: rtl/tflag_exec_unit.sv
module tflag_exec_unit
  import tfu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     op_i,
  input  logic [XLEN-1:0] rn_i,
  input  logic [XLEN-1:0] rm_i,
  output logic [XLEN-1:0] res_o,
  output logic            res_we_o,
  output logic            t_o,
  output logic            t_we_o
);
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  op_kind_e        kind;
  logic [XLEN-1:0] sub_a;
  logic [XLEN-1:0] sub_b;
  logic            sub_cin;
  logic [XLEN-1:0] sub_d;
  logic            sub_borrow;
  logic            sub_uf;
  logic [XLEN-1:0] ext_d;
  logic            ext_wide;
  logic            ext_signed;
  logic [XLEN-1:0] res_d;
  logic            res_we_d;
  logic            t_d;
  logic            t_we_d;

  tfu_decode u_dec (
    .op   (op_i),
    .kind (kind)
  );

  // Operand steering for the shared subtractor
  always_comb begin
    sub_a   = rn_i;
    sub_b   = rm_i;
    sub_cin = 1'b0;
    case (kind)
      K_NEG:   sub_a = '0;
      K_NEGC:  begin sub_a = '0; sub_cin = t_o; end
      K_SUBC:  sub_cin = t_o;
      K_DT:    sub_b = ONE;
      default: ;
    endcase
  end

  tfu_subtract #(.XLEN(XLEN)) u_sub (
    .a         (sub_a),
    .b         (sub_b),
    .cin       (sub_cin),
    .diff      (sub_d),
    .borrow    (sub_borrow),
    .underflow (sub_uf)
  );

  assign ext_wide   = (kind == K_EXTSW) || (kind == K_EXTUW);
  assign ext_signed = (kind == K_EXTSB) || (kind == K_EXTSW);

  tfu_extend #(.XLEN(XLEN)) u_ext (
    .src        (rm_i),
    .wide       (ext_wide),
    .signed_ext (ext_signed),
    .dst        (ext_d)
  );

  // Result and flag selection
  always_comb begin
    res_d    = sub_d;
    res_we_d = 1'b1;
    t_d      = t_o;
    t_we_d   = 1'b0;
    case (kind)
      K_SUB, K_NEG: ;
      K_SUBC, K_NEGC: begin t_d = sub_borrow; t_we_d = 1'b1; end
      K_SUBV: begin t_d = sub_uf; t_we_d = 1'b1; end
      K_DT:   begin t_d = (sub_d == '0); t_we_d = 1'b1; end
      K_EXTSB, K_EXTSW, K_EXTUB, K_EXTUW: res_d = ext_d;
      default: begin res_d = '0; res_we_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o    <= '0;
      res_we_o <= 1'b0;
      t_o      <= 1'b0;
      t_we_o   <= 1'b0;
    end else begin
      res_o    <= res_d;
      res_we_o <= res_we_d;
      t_we_o   <= t_we_d;
      if (t_we_d) t_o <= t_d;
    end
  end

  // R11: a flag update never happens without a result write
  a_r11_no_lone_t: assert property (@(posedge clk) disable iff (rst)
    t_we_o |-> res_we_o);

  // R3: plain subtract keeps T
  a_r3_sub_keeps_t: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && $past(op_i[15:12] == 4'h3 && op_i[3:0] == 4'h8))
      |-> (t_o == $past(t_o) && !t_we_o));

  // R8: decrement sets T from the zero test of its written value
  a_r8_dt_zero: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && $past(op_i[15:12] == 4'h4 && op_i[7:0] == 8'h10))
      |-> (t_o == (res_o == '0)));

  // R10: zero-extending a byte clears the upper bits
  a_r10_zext_byte: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && $past(op_i[15:12] == 4'h6 && op_i[3:0] == 4'hC))
      |-> (res_o[XLEN-1:8] == '0));

  // R2: T only moves on a cycle flagged by the update strobe
  a_r2_t_holds: assert property (@(posedge clk) disable iff (rst)
    !t_we_o |-> (t_o == $past(t_o)));
endmodule

// File: tb/test_tflag_exec_unit.sv
module test_tflag_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] op_i;
  logic [31:0] rn_i;
  logic [31:0] rm_i;
  logic [31:0] res_o;
  logic        res_we_o;
  logic        t_o;
  logic        t_we_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic exp_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  tflag_exec_unit i_tflag_exec_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .rn_i(rn_i), .rm_i(rm_i),
    .res_o(res_o), .res_we_o(res_we_o), .t_o(t_o), .t_we_o(t_we_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] op, input logic [31:0] rn, input logic [31:0] rm);
    @(negedge clk);
    op_i = op; rn_i = rn; rm_i = rm;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_op(input string req, input logic [31:0] res,
                           input logic we, input logic twe, input logic t);
    check({req, " result"}, res_o, res);
    check({req, " we"}, {31'd0, res_we_o}, {31'd0, we});
    check({req, " t_we"}, {31'd0, t_we_o}, {31'd0, twe});
    check({req, " T"}, {31'd0, t_o}, {31'd0, t});
  endtask

  task automatic t_reset;
    rst = 1'b1; op_i = 16'h0000; rn_i = '0; rm_i = '0;
    repeat (3) @(posedge clk);
    #1;
    expect_op("R1", 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    exp_t = 1'b0;
  endtask

  // T = 0 via decrement of 2
  task automatic clear_t;
    issue(16'h4110, 32'd2, 32'd0);
    exp_t = 1'b0;
    expect_op("R8 dt2", 32'd1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_dt;
    issue(16'h4310, 32'd1, 32'd0);
    exp_t = 1'b1;
    expect_op("R8 dt1", 32'd0, 1'b1, 1'b1, 1'b1);
    issue(16'h4310, 32'd0, 32'd0);
    exp_t = 1'b0;
    expect_op("R8 dt0", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    issue(16'h4110, 32'd1, 32'd0); exp_t = 1'b1;   // T=1
    issue(16'h3128, 32'd5, 32'd7);
    expect_op("R3 sub", 32'hFFFF_FFFE, 1'b1, 1'b0, exp_t);
  endtask

  task automatic t_subv;
    issue(16'h312B, 32'h8000_0000, 32'd1);
    exp_t = 1'b1;
    expect_op("R5 underflow", 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b1);
    issue(16'h312B, 32'd3, 32'd5);
    exp_t = 1'b0;
    expect_op("R5 no underflow", 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0);
    issue(16'h312B, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    exp_t = 1'b1;
    expect_op("R5 pos-neg", 32'h8000_0000, 1'b1, 1'b1, 1'b1);
  endtask

  // 64-bit subtraction by back-to-back chained subtracts
  task automatic t_chain;
    logic [63:0] a, b, d;
    logic        bout;
    a = 64'h0000_0005_0000_0001;
    b = 64'h0000_0002_0000_0003;
    {bout, d} = {1'b0, a} - {1'b0, b};
    clear_t();
    issue(16'h312A, a[31:0], b[31:0]);
    check("R4 low word", res_o, d[31:0]);
    check("R4 low borrow", {31'd0, t_o}, 32'd1);
    // next instruction issued immediately, consuming the fresh T (R2)
    issue(16'h312A, a[63:32], b[63:32]);
    check("R2 high word", res_o, d[63:32]);
    check("R2 final borrow", {31'd0, t_o}, {31'd0, bout});
    exp_t = bout;
  endtask

  task automatic t_neg;
    issue(16'h4110, 32'd1, 32'd0); exp_t = 1'b1;
    issue(16'h612B, 32'd0, 32'd9);
    expect_op("R6 neg", 32'hFFFF_FFF7, 1'b1, 1'b0, 1'b1);
    issue(16'h612A, 32'd0, 32'd0);
    expect_op("R7 negc T=1", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
    clear_t();
    issue(16'h612A, 32'd0, 32'd0);
    expect_op("R7 negc zero", 32'd0, 1'b1, 1'b1, 1'b0);
    issue(16'h612A, 32'd0, 32'd4);
    expect_op("R7 negc rm", 32'hFFFF_FFFC, 1'b1, 1'b1, 1'b1);
    exp_t = 1'b1;
  endtask

  task automatic t_ext;
    issue(16'h612E, 32'd0, 32'h1234_5680);
    expect_op("R9 sext byte", 32'hFFFF_FF80, 1'b1, 1'b0, exp_t);
    issue(16'h612F, 32'd0, 32'h0000_7F01);
    expect_op("R9 sext word", 32'h0000_7F01, 1'b1, 1'b0, exp_t);
    issue(16'h612C, 32'd0, 32'hFFFF_FFA5);
    expect_op("R10 zext byte", 32'h0000_00A5, 1'b1, 1'b0, exp_t);
    issue(16'h612D, 32'd0, 32'hFFFF_8001);
    expect_op("R10 zext word", 32'h0000_8001, 1'b1, 1'b0, exp_t);
  endtask

  task automatic t_illegal;
    issue(16'hFFFF, 32'd1, 32'd1);
    expect_op("R11 ffff", 32'h0, 1'b0, 1'b0, exp_t);
    issue(16'h4111, 32'd1, 32'd0);
    expect_op("R11 near dt", 32'h0, 1'b0, 1'b0, exp_t);
  endtask

  initial begin
    t_reset();
    t_dt();
    t_sub();
    t_subv();
    t_chain();
    t_neg();
    t_ext();
    t_illegal();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule